// File: doc/BRIEF.md
# Third-Order Noise-Shaped Fractional Divide-Value Generator

This block feeds the feedback divider of a fractional-N phase-locked loop. On every divider cycle, signalled by a one-cycle `tick_i` strobe, it presents the integer modulus that the counter uses next. That value is the integer part plus a small signed correction. Over time the corrections average out to FRAC/MOD, so the loop locks to INT + FRAC/MOD times the comparison frequency.

The correction comes from three cascaded accumulators. Each one wraps at a programmable modulus. Stage one adds FRAC. Each later stage adds the residue that the stage before it left. A cancellation network takes the first difference of the second stage's carry and the second difference of the third stage's carry. This pushes the quantisation error to high offset frequencies. New settings are captured on `load_i`. They take effect at the next tick, which clears every accumulator and delay and outputs the bare integer.

Top module: `mash_frac_div`

## Requirements
- R1: A `load_i` pulse captures `int_i`, `frac_i` and `mod_i`. The next `tick_i` clears all accumulator and delay state and sets `div_o` to the new integer and `corr_o` to 0. Until that tick, `div_o` keeps its previous value.
- R2: `div_o` and `corr_o` change only in the cycle after a `tick_i` strobe. Cycles without a tick leave both unchanged.
- R3: On each tick, each accumulator stage adds its input to its residue. When the sum reaches or exceeds MOD, the stage asserts its carry and keeps the sum minus MOD. The input of stage one is FRAC, and the input of each later stage is the new residue of the stage before it.
- R4: The correction on each tick equals c1 + (c2 − c2') + (c3 − 2·c3' + c3''). Here ' is the carry from the previous tick and '' the carry from two ticks earlier, with all of these taken as 0 before the first tick after a reload. `corr_o` is a 4-bit two's-complement value, and `div_o` = INT + `corr_o`.
- R5: `corr_o` stays within −3..+4. `div_o` stays within INT−3..INT+4 and is a 10-bit unsigned value, so INT = 511 still fits.
- R6: When FRAC is 0, every tick gives `div_o` = INT and `corr_o` = 0.
- R7: Over the MOD ticks that follow a reload tick, the corrections sum to FRAC within −1..+2.
- R8: After reset, `div_o` and `corr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One strobe per divider cycle |
| load_i | input | 1 | Capture new settings; they apply at the next tick |
| int_i | input | 9 | Integer part of the divide ratio |
| frac_i | input | 12 | Fractional numerator, must be below `mod_i` |
| mod_i | input | 12 | Fractional modulus (accumulator wrap point) |
| div_o | output | 10 | Divide value for the current divider cycle |
| corr_o | output | 4 | Signed correction applied to INT |

## Verification
The bench sets up several settings and compares every tick against an independent integer model of the three wrapping stages. A modulus of 4095 with FRAC = 1 shows the rare-carry case, where only higher-stage dithering is active. FRAC = 4094 keeps stage one carrying almost every tick and drives INT = 511 to the top of the range. INT = 3 with a half-scale fraction pushes the output toward zero. Small moduli such as 10 and 13 separate a wrap at MOD from a wrap at a power of two. Gapped ticks and a reload in the middle of a stream separate "hold between ticks" from "apply at the next tick". The sum over a full period checks the average ratio.

// File: rtl/mash_pkg.sv
package mash_pkg;
  localparam int STAGES = 3;
  localparam int CORR_W = 4;
  typedef logic signed [CORR_W-1:0] corr_t;
endpackage

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         clear_i,
  input  logic [W-1:0] mod_i,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] res_o,
  output logic         carry_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;
  logic [W:0]   wrapped;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, in_i};
    carry_o = (sum >= {1'b0, mod_i});
    wrapped = sum - {1'b0, mod_i};
    res_o   = carry_o ? wrapped[W-1:0] : sum[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (step_i)  acc_q <= res_o;
  end

  // R1
  stage_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (acc_q == '0));

  // R3
  stage_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i && acc_q < mod_i && in_i < mod_i) |=> (acc_q < $past(mod_i)));
endmodule

// File: rtl/mash_cancel.sv
module mash_cancel
  import mash_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              clear_i,
  input  logic [STAGES-1:0] carry_i,
  output corr_t             corr_o
);
  localparam int CW = CORR_W + 1;

  logic         c2_d, c3_d, c3_d2;
  logic [CW-1:0] total;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c2_d <= 1'b0; c3_d <= 1'b0; c3_d2 <= 1'b0;
    end else if (clear_i) begin
      c2_d <= 1'b0; c3_d <= 1'b0; c3_d2 <= 1'b0;
    end else if (step_i) begin
      c2_d  <= carry_i[1];
      c3_d  <= carry_i[2];
      c3_d2 <= c3_d;
    end
  end

  // modular sum in CW bits, read back as signed
  always_comb begin
    total  = CW'(carry_i[0]) + CW'(carry_i[1]) - CW'(c2_d)
           + CW'(carry_i[2]) - CW'({c3_d, 1'b0}) + CW'(c3_d2);
    corr_o = corr_t'(total[CORR_W-1:0]);
  end

  // R5
  corr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corr_o >= -4'sd3) && (corr_o <= 4'sd4));
endmodule

// File: rtl/mash_frac_div.sv
module mash_frac_div
  import mash_pkg::*;
#(
  parameter int INT_W  = 9,
  parameter int FRAC_W = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic                     load_i,
  input  logic [INT_W-1:0]         int_i,
  input  logic [FRAC_W-1:0]        frac_i,
  input  logic [FRAC_W-1:0]        mod_i,
  output logic [INT_W:0]           div_o,
  output logic signed [CORR_W-1:0] corr_o
);
  localparam int DIV_W = INT_W + 1;

  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q, mod_q;
  logic              pend_q;
  logic              clear, step;
  logic [FRAC_W-1:0] res [STAGES];
  logic [STAGES-1:0] carry;
  corr_t             corr_raw, corr_sel;
  logic [DIV_W-1:0]  int_ext, corr_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q <= '0; frac_q <= '0; mod_q <= '0; pend_q <= 1'b0;
    end else begin
      if (load_i) begin
        int_q  <= int_i;
        frac_q <= frac_i;
        mod_q  <= mod_i;
      end
      if (load_i)      pend_q <= 1'b1;
      else if (tick_i) pend_q <= 1'b0;
    end
  end

  assign clear = tick_i & pend_q;
  assign step  = tick_i & ~pend_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [FRAC_W-1:0] stage_in;
    if (s == 0) begin : g_first
      assign stage_in = frac_q;
    end else begin : g_next
      assign stage_in = res[s-1];
    end
    mash_acc_stage #(.W(FRAC_W)) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (step),
      .clear_i (clear),
      .mod_i   (mod_q),
      .in_i    (stage_in),
      .res_o   (res[s]),
      .carry_o (carry[s])
    );
  end

  mash_cancel u_cancel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .clear_i (clear),
    .carry_i (carry),
    .corr_o  (corr_raw)
  );

  always_comb begin
    corr_sel = (frac_q == '0) ? corr_t'(0) : corr_raw;
    int_ext  = {{(DIV_W-INT_W){1'b0}}, int_q};
    corr_ext = {{(DIV_W-CORR_W){corr_sel[CORR_W-1]}}, corr_sel};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o  <= '0;
      corr_o <= '0;
    end else if (clear) begin
      div_o  <= int_ext;
      corr_o <= '0;
    end else if (step) begin
      div_o  <= int_ext + corr_ext;
      corr_o <= corr_sel;
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(div_o) && $stable(corr_o)));

  // R1
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && pend_q) |=> (div_o == $past(int_ext)) && (corr_o == '0));

  // R6
  frac_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !pend_q && frac_q == '0) |=> (div_o == $past(int_ext)));

  // R5
  div_bounds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !pend_q && int_q >= INT_W'(3)) |=>
      (({1'b0, div_o} + (DIV_W+1)'(3)) >= {1'b0, $past(int_ext)}) &&
      ({1'b0, div_o} <= ({1'b0, $past(int_ext)} + (DIV_W+1)'(4))));

  // R3
  last_res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && mod_q != '0 && frac_q < mod_q) |-> (res[STAGES-1] < mod_q));
endmodule

// File: tb/mash_frac_div_bench.sv
module mash_frac_div_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              tick_i = 1'b0;
  logic              load_i = 1'b0;
  logic [8:0]        int_i = '0;
  logic [11:0]       frac_i = '0;
  logic [11:0]       mod_i = '0;
  logic [9:0]        div_o;
  logic signed [3:0] corr_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int a1, a2, a3, c2d, c3d, c3d2;
  int m_int, m_frac, m_mod;

  always #2 clk_i = ~clk_i;

  mash_frac_div u_mash_frac_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .load_i(load_i),
    .int_i(int_i), .frac_i(frac_i), .mod_i(mod_i),
    .div_o(div_o), .corr_o(corr_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    n_run++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic model_clear();
    a1 = 0; a2 = 0; a3 = 0; c2d = 0; c3d = 0; c3d2 = 0;
  endtask

  task automatic model_step(output int corr);
    int c1, c2, c3;
    a1 += m_frac; c1 = (a1 >= m_mod); if (c1 != 0) a1 -= m_mod;
    a2 += a1;     c2 = (a2 >= m_mod); if (c2 != 0) a2 -= m_mod;
    a3 += a2;     c3 = (a3 >= m_mod); if (c3 != 0) a3 -= m_mod;
    corr = c1 + c2 - c2d + c3 - 2 * c3d + c3d2;
    if (m_frac == 0) corr = 0;
    c3d2 = c3d; c3d = c3; c2d = c2;
  endtask

  // all tasks start and end on a falling edge
  task automatic do_tick();
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic load_cfg(input int i, input int f, input int m);
    int_i = 9'(i); frac_i = 12'(f); mod_i = 12'(m);
    load_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic reload(input int i, input int f, input int m);
    load_cfg(i, f, m);
    do_tick();
    check("R1 reload div", int'(div_o), i);
    check("R1 reload corr", int'(corr_o), 0);
    m_int = i; m_frac = f; m_mod = m;
    model_clear();
  endtask

  task automatic t_reset();
    check("R8 reset div", int'(div_o), 0);
    check("R8 reset corr", int'(corr_o), 0);
  endtask

  task automatic t_frac_zero();
    reload(100, 0, 7);
    for (int k = 0; k < 20; k++) begin
      do_tick();
      check("R6 frac zero div", int'(div_o), 100);
      check("R6 frac zero corr", int'(corr_o), 0);
    end
  endtask

  task automatic t_seq(input int i, input int f, input int m, input int n, input int gap);
    int e, sum, hold;
    sum = 0;
    reload(i, f, m);
    for (int k = 0; k < n; k++) begin
      do_tick();
      model_step(e);
      check("R3 R4 sequence div", int'(div_o), i + e);
      check("R4 sequence corr", int'(corr_o), e);
      check_range("R5 div bounds", int'(div_o), (i > 3) ? i - 3 : 0, i + 4);
      check_range("R5 corr bounds", int'(corr_o), -3, 4);
      sum += int'(corr_o);
      for (int g = 0; g < gap; g++) begin
        hold = int'(div_o);
        @(negedge clk_i);
        check("R2 hold without tick", int'(div_o), hold);
      end
    end
    if (n == m) check_range("R7 average over period", sum - f, -1, 2);
  endtask

  task automatic t_load_hold();
    int e, hold;
    reload(40, 3, 11);
    for (int k = 0; k < 9; k++) begin
      do_tick();
      model_step(e);
    end
    hold = int'(div_o);
    load_cfg(300, 5, 9);
    repeat (4) @(negedge clk_i);
    check("R1 load waits for tick", int'(div_o), hold);
    check("R2 idle after load", int'(div_o), hold);
    do_tick();
    check("R1 mid-stream reload div", int'(div_o), 300);
    check("R1 mid-stream reload corr", int'(corr_o), 0);
    m_int = 300; m_frac = 5; m_mod = 9;
    model_clear();
    for (int k = 0; k < 18; k++) begin
      do_tick();
      model_step(e);
      check("R1 R4 state cleared after reload", int'(div_o), 300 + e);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #760000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_frac_zero();
    t_seq(50, 1, 4095, 4095, 0);
    t_seq(511, 4094, 4095, 4095, 0);
    t_seq(3, 2047, 4095, 300, 0);
    t_seq(200, 3, 10, 10, 0);
    t_seq(77, 5, 13, 13, 2);
    t_seq(120, 12, 13, 40, 1);
    t_load_hold();
    done = 1;
    summary();
    $finish;
  end
endmodule